// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one channel of a compare-match timer. A prescaler divides the system clock by one of four fixed ratios. Each prescaled tick advances a counter. When the counter holds the same value as the compare register on a tick, it goes back to zero and a sticky match flag is raised. The flag drives an interrupt line when the interrupt enable is set.

Software reaches three registers over a narrow synchronous register bus. These are a control/status word, the live counter and the compare value. Counting is allowed by one bit of a start vector that the channels share. That vector is kept outside the block and is fed in as an input. The bit this channel listens to is chosen by a parameter that gives its hardware index.

To clear the match flag, software reads the control word and writes it back with the flag bit at zero. Writing a one to the flag bit leaves the flag as it is. The period of the channel is compare + 1 ticks.

Top module: `cmt_channel`

## Requirements
- R1: After reset the control word and the counter read 0, the compare register reads 0xFFFF, `irq` is low and the channel does not count.
- R2: Word address 0 is the control word, 1 is the counter and 2 is the compare value. In the control word, bit 7 is the match flag, bit 6 is the interrupt enable, bits 1:0 are the clock code and all other bits read 0. Address 3 reads 0. Read data appears on `bus_rdata` in the cycle after the read request.
- R3: Clock code 0, 1, 2 and 3 make one counter tick every 8, 32, 128 and 512 clocks respectively.
- R4: The counter advances only while `start_vec[CH_IDX]` is 1. The other start bits have no effect. A stopped counter holds its value.
- R5: On a tick where the counter equals the compare value, the counter becomes 0 and the match flag is set. With compare C and divisor D, the flag rises on the (C+1)·D-th clock after the start bit is raised.
- R6: A write to the control word with bit 7 at 0 clears the flag. A write with bit 7 at 1 leaves the flag unchanged.
- R7: If a match and a flag-clearing control write happen in the same cycle, the flag ends up set.
- R8: `irq` is high exactly when both the match flag and the interrupt enable are set.
- R9: The counter and compare registers take written values. A counter write takes priority over a tick that falls in the same cycle.
- R10: The prescaler restarts from zero each time the start bit rises. A partial prescale count is not kept across a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| start_vec | input | START_W | Shared start bits; bit CH_IDX runs this channel |
| irq | output | 1 | Interrupt request, registered |

## Verification
The bench drives the flag clear in the same clock as a match. A design that let the clear win would drop an event, and `irq` would stay low. It stops the channel part-way through a prescale and starts it again, then checks the flag timing. A prescaler that kept its count would match several clocks early. It writes the counter in the very cycle of a tick, where a design with the wrong priority would show the incremented value. It writes a one to the flag bit and checks that this does not clear the flag, and it checks all four dividers by the exact clock on which the flag rises, so a divider off by one misses that cycle.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int REG_W     = 16;
  localparam int REG_ADDR_W = 2;
  localparam int CODE_W    = 2;
  localparam int FLAG_BIT  = 7;
  localparam int IE_BIT    = 6;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_MATCH = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int BASE_SHIFT = 3,
  parameter int STEP_SHIFT = 2,
  parameter int CODE_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int NCODES    = 1 << CODE_W;
  localparam int MAX_SHIFT = BASE_SHIFT + STEP_SHIFT * (NCODES - 1);
  localparam int PRE_W     = MAX_SHIFT;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim_tab [NCODES];
  logic [PRE_W-1:0] limit;
  logic             wrap;

  // Terminal count for each code: divisor minus one.
  for (genvar g = 0; g < NCODES; g++) begin : g_lim
    localparam int SH = BASE_SHIFT + STEP_SHIFT * g;
    assign lim_tab[g] = {PRE_W{1'b1}} >> (PRE_W - SH);
  end

  assign limit = lim_tab[code];
  assign wrap  = (pre_q >= limit);
  assign tick  = run && wrap;

  // Held at zero while stopped, so every start begins a fresh prescale.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_q <= '0;
    end else if (wrap) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         cnt_we,
  input  logic         cmp_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cmp_q,
  output logic         match
);
  assign match = tick && (cnt_q == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      cmp_q <= '1;
    end else begin
      if (cnt_we) begin
        cnt_q <= wdata;
      end else if (tick) begin
        cnt_q <= match ? '0 : cnt_q + 1'b1;
      end
      if (cmp_we) begin
        cmp_q <= wdata;
      end
    end
  end
endmodule

// File: rtl/cmt_ctrl.sv
module cmt_ctrl #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              w_flag,
  input  logic              w_ie,
  input  logic [CODE_W-1:0] w_code,
  input  logic              match,
  output logic              flag_q,
  output logic              ie_q,
  output logic [CODE_W-1:0] code_q,
  output logic              irq
);
  logic flag_d;
  logic ie_d;

  always_comb begin
    flag_d = flag_q;
    if (match) begin
      flag_d = 1'b1;
    end else if (we && !w_flag) begin
      flag_d = 1'b0;
    end
    ie_d = we ? w_ie : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      code_q <= '0;
      irq    <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ie_q   <= ie_d;
      irq    <= flag_d && ie_d;
      if (we) begin
        code_q <= w_code;
      end
    end
  end
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int DATA_W  = REG_W,
  parameter int START_W = 8,
  parameter int CH_IDX  = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [START_W-1:0]    start_vec,
  output logic                  irq
);
  localparam logic [START_W-1:0] RUN_MASK = START_W'(1) << CH_IDX;

  reg_sel_e           sel;
  logic               wr_ctrl, wr_cnt, wr_cmp, rd_req;
  logic               run, tick, match;
  logic               flag_q, ie_q;
  logic [CODE_W-1:0]  code_q;
  logic [DATA_W-1:0]  cnt_q, cmp_q, ctrl_view, rd_mux;

  assign sel     = reg_sel_e'(bus_addr);
  assign wr_ctrl = bus_sel && bus_wr && (sel == REG_CTRL);
  assign wr_cnt  = bus_sel && bus_wr && (sel == REG_COUNT);
  assign wr_cmp  = bus_sel && bus_wr && (sel == REG_MATCH);
  assign rd_req  = bus_sel && !bus_wr;
  assign run     = |(start_vec & RUN_MASK);

  cmt_prescaler #(.BASE_SHIFT(3), .STEP_SHIFT(2), .CODE_W(CODE_W)) u_pre (
    .clk(clk), .rst(rst), .run(run), .code(code_q), .tick(tick)
  );

  cmt_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .cnt_we(wr_cnt), .cmp_we(wr_cmp),
    .wdata(bus_wdata), .cnt_q(cnt_q), .cmp_q(cmp_q), .match(match)
  );

  cmt_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rst(rst), .we(wr_ctrl),
    .w_flag(bus_wdata[FLAG_BIT]), .w_ie(bus_wdata[IE_BIT]),
    .w_code(bus_wdata[CODE_W-1:0]), .match(match),
    .flag_q(flag_q), .ie_q(ie_q), .code_q(code_q), .irq(irq)
  );

  always_comb begin
    ctrl_view                = '0;
    ctrl_view[FLAG_BIT]      = flag_q;
    ctrl_view[IE_BIT]        = ie_q;
    ctrl_view[CODE_W-1:0]    = code_q;
    unique case (sel)
      REG_CTRL:  rd_mux = ctrl_view;
      REG_COUNT: rd_mux = cnt_q;
      REG_MATCH: rd_mux = cmp_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_req) begin
      bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/cmt_channel_chk.sv
module cmt_channel_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              tick,
  input logic              match,
  input logic              cnt_we,
  input logic              ctrl_we,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] cmp,
  input logic              flag,
  input logic              ie,
  input logic              irq
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (cmp == '1) && (cnt == '0) && !flag && !irq);

  p_hold_stopped_r4: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_we) |=> $stable(cnt));

  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && (cnt == cmp) && !cnt_we) |=> (cnt == '0) && flag);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (flag && !(ctrl_we && !wdata[7])) |=> flag);

  p_match_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (match && ctrl_we) |=> flag);

  p_irq_needs_both_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag && ie));

  p_irq_follows_r8: assert property (@(posedge clk) disable iff (rst)
    (flag && ie) |-> irq);

  p_cnt_write_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> (cnt == $past(wdata)));
endmodule

bind cmt_channel cmt_channel_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .tick(tick), .match(match),
  .cnt_we(wr_cnt), .ctrl_we(wr_ctrl), .wdata(bus_wdata),
  .cnt(cnt_q), .cmp(cmp_q), .flag(flag_q), .ie(ie_q), .irq(irq)
);

// File: tb/cmt_channel_tb.sv
module cmt_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int START_W    = 4;
  localparam int CH_IDX     = 1;
  localparam logic [START_W-1:0] MY_BIT = START_W'(1) << CH_IDX;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [START_W-1:0] start_vec = '0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        pend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmt_channel #(.DATA_W(16), .START_W(START_W), .CH_IDX(CH_IDX)) u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .start_vec(start_vec), .irq(irq)
  );

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Monitor: a read accepted on an edge is compared at the following falling edge.
  always @(posedge clk) pend <= bus_sel && !bus_wr && !rst;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        errors++; checks++;
        $display("FAIL R2: read data with empty scoreboard, got %h expected none", bus_rdata);
      end else begin
        chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wait_e(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic flag_at(input int n, input string tag);
    start_vec = MY_BIT;
    wait_e(n - 1);
    chk(16'(irq), 16'd0, {tag, " one clock before match"});
    wait_e(1);
    chk(16'(irq), 16'd1, {tag, " at match"});
    start_vec = '0;
  endtask

  initial begin
    wait_e(3);
    rst = 1'b0;
    // R1 / R2 reset view
    rd(2'd0, 16'h0000, "R1 control after reset");
    rd(2'd1, 16'h0000, "R1 counter after reset");
    rd(2'd2, 16'hFFFF, "R1 compare after reset");
    rd(2'd3, 16'h0000, "R2 unused address");
    chk(16'(irq), 16'd0, "R1 irq after reset");

    // R5 / R8: compare 3, divide by 8 -> flag on clock 32
    wr(2'd2, 16'd3);
    wr(2'd0, 16'h0040);
    rd(2'd2, 16'd3, "R9 compare write");
    flag_at(32, "R5 period");
    rd(2'd1, 16'h0000, "R5 counter back to zero");
    rd(2'd0, 16'h00C0, "R2 control with flag and enable");

    // R6 clear protocol
    wr(2'd0, 16'h00C0);
    rd(2'd0, 16'h00C0, "R6 writing one keeps flag");
    chk(16'(irq), 16'd1, "R6 irq kept");
    wr(2'd0, 16'h0040);
    chk(16'(irq), 16'd0, "R6 irq after clear");
    rd(2'd0, 16'h0040, "R6 flag cleared");

    // R3 dividers
    wr(2'd2, 16'd1);
    wr(2'd0, 16'h0041);
    flag_at(64, "R3 divide 32");
    wr(2'd2, 16'd0);
    wr(2'd0, 16'h0042);
    flag_at(128, "R3 divide 128");
    wr(2'd0, 16'h0043);
    flag_at(512, "R3 divide 512");

    // R8 enable off with flag set
    wr(2'd0, 16'h0000);
    start_vec = MY_BIT;
    wait_e(8);
    start_vec = '0;
    chk(16'(irq), 16'd0, "R8 irq masked");
    rd(2'd0, 16'h0080, "R8 flag set while masked");
    wr(2'd0, 16'h00C0);
    chk(16'(irq), 16'd1, "R8 irq on enabling");
    wr(2'd0, 16'h0040);

    // R10 prescaler restart
    start_vec = MY_BIT;
    wait_e(5);
    start_vec = '0;
    wait_e(2);
    flag_at(8, "R10 restart");
    wr(2'd0, 16'h0040);

    // R7 match and clear in one cycle
    start_vec = MY_BIT;
    wait_e(7);
    wr(2'd0, 16'h0040);
    start_vec = '0;
    chk(16'(irq), 16'd1, "R7 match beats clear");
    rd(2'd0, 16'h00C0, "R7 flag kept");
    wr(2'd0, 16'h0040);

    // R4 other start bits, running count, hold when stopped
    wr(2'd2, 16'd100);
    wr(2'd1, 16'd0);
    start_vec = ~MY_BIT;
    wait_e(40);
    rd(2'd1, 16'd0, "R4 other start bits ignored");
    chk(16'(irq), 16'd0, "R4 no irq from other bits");
    start_vec = MY_BIT;
    wait_e(24);
    rd(2'd1, 16'd3, "R4 counter while running");
    start_vec = '0;
    wait_e(20);
    rd(2'd1, 16'd3, "R4 counter held when stopped");

    // R9 counter writes
    wr(2'd1, 16'h1234);
    rd(2'd1, 16'h1234, "R9 counter write");
    wr(2'd1, 16'd0);
    rd(2'd1, 16'd0, "R9 counter write zero");
    start_vec = MY_BIT;
    wait_e(7);
    wr(2'd1, 16'd50);
    start_vec = '0;
    rd(2'd1, 16'd50, "R9 write beats tick");

    wait_e(3);
    if (exp_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL R2: %0d reads unanswered, expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule